// File: doc/BRIEF.md
# Butterfly Accumulate and Round-Shift Unit

This unit finishes a two-coefficient butterfly. It takes two running sums, an operand `b` and a coefficient `d`. It forms the low word of the signed product `p = b*d`. It adds `p` to the first sum and subtracts the same `p` from the second sum. Both results are then rounded and scaled by 2^-n with one shared shift amount `n`. Both sums are read and replaced in the same operation, so the pair of destinations behaves as a read-modify-write pair.

The unit is used as the second of two steps. In the first step, a twin butterfly stage runs with shift 0 and coefficient `c1` and produces `a*c1 + b*c1` and `a*c1 - b*c1`. In the second step, this unit receives those two values with `d = c2 - c1` and the wanted shift. Its outputs are then `round(a*c1 + b*c2)` and `round(a*c1 - b*c2)`. All arithmetic wraps at the operand width. The outputs are registered and appear one cycle after the request.

Top module: `bfly_acc_round`

## Requirements
- R1: The product `p` is the low `W` bits of the signed product `opB*coef`. The upper half is discarded.
- R2: Before scaling, the primary result is `accPri + p`, wrapped to `W` bits.
- R3: Before scaling, the secondary result is `accSec - p`, wrapped to `W` bits.
- R4: For `shAmt = n > 0`, `2^(n-1)` is added to each accumulated value before an arithmetic right shift by `n`. This rounds ties upward, so 1>>1 gives 1 and -1>>1 gives 0.
- R5: The rounding add wraps at `W` bits. The shifted result is sign-extended from bit `W-1` of that wrapped value. For example, 0x7FFFFFFF with n=1 gives 0xC0000000.
- R6: `shAmt = 0` passes both accumulated values through unchanged, with no rounding.
- R7: `outValid` is high in exactly the cycle after each cycle in which `inValid` is high, and at no other time. Back-to-back requests give back-to-back results.
- R8: While `outValid` is low after a result, `resPri` and `resSec` hold the last result.
- R9: During reset, `outValid` is 0 and both results are 0.
- R10: Feeding this unit with the outputs of a shift-0 twin stage for coefficient `c1`, and using `d = c2 - c1`, gives `round(a*c1 + b*c2)` and `round(a*c1 - b*c2)` as defined by R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe; the operands below are taken on this cycle |
| accPri | input | W | First running sum; the product is added to it |
| accSec | input | W | Second running sum; the product is subtracted from it |
| opB | input | W | Multiplicand operand |
| coef | input | W | Coefficient (`c2 - c1` in the chained use) |
| shAmt | input | SHW | Round-shift amount `n` |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| resPri | output | W | Rounded primary result |
| resSec | output | W | Rounded secondary result |

## Verification
The hardest case to reach is a rounding add that crosses the sign boundary (R5). Random operands almost never land within a few counts of 0x7FFFFFFF after the accumulate. The stimulus therefore builds the sum directly: it sets the product to zero and places the accumulator at the edge value. Exact half-way ties at n=1 are also placed directly, in both signs. The two-step use (R10) is covered by a bench model of the shift-0 twin stage feeding the unit with random `a`, `b`, `c1`, `c2`. The result is compared with the direct formula, so the wrap identity that the chaining relies on is checked independently of the unit's own arithmetic.

// File: rtl/bfly_acc_pkg.sv
package bfly_acc_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // load the output registers this cycle
    logic bypass;   // shift amount is zero: no rounding
  } bflyStrobe_t;
endpackage

// File: rtl/bfly_acc_ctrl.sv
module bfly_acc_ctrl
  import bfly_acc_pkg::*;
#(
  parameter int SHW = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [SHW-1:0] shAmt,
  output bflyStrobe_t    strobe,
  output logic           outValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.bypass  = (shAmt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/bfly_acc_dp.sv
module bfly_acc_dp
  import bfly_acc_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  bflyStrobe_t    strobe,
  input  logic [W-1:0]   accPri,
  input  logic [W-1:0]   accSec,
  input  logic [W-1:0]   opB,
  input  logic [W-1:0]   coef,
  input  logic [SHW-1:0] shAmt,
  output logic [W-1:0]   resPri,
  output logic [W-1:0]   resSec
);
  localparam int LANES = 2;
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] prodLo;
  logic [W-1:0] roundK;
  logic [LANES-1:0][W-1:0] accIn;
  logic [LANES-1:0][W-1:0] resQ;

  // low word of the product equals the low word of the signed product
  assign prodLo = opB * coef;
  assign roundK = strobe.bypass ? '0 : (ONE << (shAmt - SHW'(1)));
  assign accIn[0] = accPri;
  assign accIn[1] = accSec;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [W-1:0] sumV;
    logic [W-1:0] rndV;
    logic [W-1:0] shV;

    if (g == 0) begin : gAdd
      assign sumV = accIn[g] + prodLo;
    end else begin : gSub
      assign sumV = accIn[g] - prodLo;
    end

    assign rndV = sumV + roundK;
    assign shV  = W'($signed(rndV) >>> shAmt);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              resQ[g] <= '0;
      else if (strobe.capture) resQ[g] <= shV;
    end
  end

  assign resPri = resQ[0];
  assign resSec = resQ[1];
endmodule

// File: rtl/bfly_acc_round.sv
module bfly_acc_round
  import bfly_acc_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [W-1:0]   accPri,
  input  logic [W-1:0]   accSec,
  input  logic [W-1:0]   opB,
  input  logic [W-1:0]   coef,
  input  logic [SHW-1:0] shAmt,
  output logic           outValid,
  output logic [W-1:0]   resPri,
  output logic [W-1:0]   resSec
);
  bflyStrobe_t strobe;

  bfly_acc_ctrl #(.SHW(SHW)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .shAmt(shAmt),
    .strobe(strobe), .outValid(outValid)
  );

  bfly_acc_dp #(.W(W), .SHW(SHW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accPri(accPri), .accSec(accSec), .opB(opB), .coef(coef),
    .shAmt(shAmt), .resPri(resPri), .resSec(resSec)
  );
endmodule

// File: rtl/bfly_acc_round_chk.sv
module bfly_acc_round_chk #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic [W-1:0]   accPri,
  input logic [W-1:0]   accSec,
  input logic [W-1:0]   coef,
  input logic [SHW-1:0] shAmt,
  input logic           outValid,
  input logic [W-1:0]   resPri,
  input logic [W-1:0]   resSec
);
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R7
  valid_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(resPri) && $stable(resSec)));

  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && shAmt == '0 && coef == '0) |=>
      (resPri == $past(accPri) && resSec == $past(accSec)));

  // R9
  reset_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && resPri == '0 && resSec == '0));
endmodule

bind bfly_acc_round bfly_acc_round_chk #(.W(W), .SHW(SHW)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .accPri(accPri),
  .accSec(accSec), .coef(coef), .shAmt(shAmt), .outValid(outValid),
  .resPri(resPri), .resSec(resSec)
);

// File: tb/bfly_acc_round_tb.sv
module bfly_acc_round_tb;
  localparam int W = 32;
  localparam int SHW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, inValid, outValid;
  logic [W-1:0] accPri, accSec, opB, coef, resPri, resSec;
  logic [SHW-1:0] shAmt;

  bfly_acc_round #(.W(W), .SHW(SHW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accPri(accPri),
    .accSec(accSec), .opB(opB), .coef(coef), .shAmt(shAmt),
    .outValid(outValid), .resPri(resPri), .resSec(resSec)
  );

  typedef struct {
    logic [W-1:0] r1;
    logic [W-1:0] r2;
    string tag;
  } expItem_t;

  expItem_t sbq[$];
  expItem_t lastItem;
  bit haveLast = 0;
  int nChk = 0;
  int nBad = 0;

  // R4/R5 model: wrap at W, add half, arithmetic shift
  function automatic logic [W-1:0] roundSh(logic [W-1:0] s, int n);
    logic [W-1:0] r;
    if (n == 0) return s;  // R6
    r = s + (W'(1) << (n - 1));
    return W'($signed(r) >>> n);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [W-1:0] a1, logic [W-1:0] a2,
                       logic [W-1:0] b, logic [W-1:0] d, int n);
    expItem_t e;
    logic [W-1:0] p;
    @(negedge clk);
    accPri = a1; accSec = a2; opB = b; coef = d; shAmt = SHW'(n);
    inValid = 1'b1;
    p = W'(b * d);  // R1
    e.r1 = roundSh(a1 + p, n);  // R2
    e.r2 = roundSh(a2 - p, n);  // R3
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      accPri = $urandom; accSec = $urandom; opB = $urandom; coef = $urandom;
    end
  endtask

  // R10: two-step chain versus direct formula
  task automatic chain(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c1,
                       logic [W-1:0] c2, int n);
    logic [W-1:0] t1, t2, x, y;
    expItem_t e;
    t1 = W'(a * c1) + W'(b * c1);
    t2 = W'(a * c1) - W'(b * c1);
    x = W'(a * c1) + W'(b * c2);
    y = W'(a * c1) - W'(b * c2);
    @(negedge clk);
    accPri = t1; accSec = t2; opB = b; coef = c2 - c1; shAmt = SHW'(n);
    inValid = 1'b1;
    e.r1 = roundSh(x, n);
    e.r2 = roundSh(y, n);
    e.tag = "R10";
    sbq.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (sbq.size() == 0) begin
          nChk++; nBad++;
          $display("FAIL R7 actual=outValid expected=idle");
        end else begin
          lastItem = sbq.pop_front();
          check({lastItem.tag, " pri"}, resPri, lastItem.r1);
          check({lastItem.tag, " sec"}, resSec, lastItem.r2);
          haveLast = 1;
        end
      end else if (haveLast) begin
        check("R8 hold pri", resPri, lastItem.r1);
        check("R8 hold sec", resSec, lastItem.r2);
      end
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0;
    accPri = '0; accSec = '0; opB = '0; coef = '0; shAmt = '0;
    repeat (3) @(negedge clk);
    check("R9 outValid", W'(outValid), '0);
    check("R9 resPri", resPri, '0);
    check("R9 resSec", resSec, '0);
    rstN = 1'b1;
    idle(2);

    drive("R6 bypass", 32'h1234_5678, 32'h8765_4321, 32'd3, 32'd7, 0);
    drive("R1 lowhalf", 32'd5, 32'd9, 32'h0001_0000, 32'h0001_0000, 0);
    drive("R1 negprod", 32'd0, 32'd0, 32'hFFFF_FFFF, 32'd6, 0);
    idle(2);
    drive("R4 tie pos", 32'd1, 32'd3, 32'd0, 32'd0, 1);
    drive("R4 tie neg", 32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'd0, 32'd0, 1);
    drive("R5 wrap", 32'h7FFF_FFFF, 32'h8000_0000, 32'd0, 32'd0, 1);
    drive("R4 n31", 32'h4000_0000, 32'hC000_0000, 32'd0, 32'd0, 31);
    drive("R2R3 n14", 32'd100000, 32'd100000, 32'd11585, 32'd3, 14);
    idle(3);
    // R7 back-to-back random mix
    for (int i = 0; i < 40; i++) begin
      drive("R2R3 rnd", $urandom, $urandom, $urandom, $urandom, $urandom % 32);
      if (i % 7 == 0) idle(1);
    end
    idle(2);
    for (int i = 0; i < 40; i++) begin
      chain($urandom % 65536 - 32768, $urandom % 65536 - 32768,
            $urandom % 32768, $urandom % 32768, (i % 3 == 0) ? 14 : $urandom % 32);
    end
    idle(4);
    nChk++;
    if (sbq.size() != 0) begin
      nBad++;
      $display("FAIL R7 actual=%0d pending expected=0", sbq.size());
    end
    finishRun();
  end
endmodule